// File: doc/BRIEF.md
# Sample Output Formatter

This block is the digital output stage of a 16-bit sampling converter. Each clock it takes one raw signed sample, as a two's complement word, plus two out-of-range indications from the front end. It clamps the sample when an indication is active and raises an overrange flag. It then encodes the word in one of three codes: offset binary, two's complement or reflected binary (Gray) code. The result is carried through a fixed-latency delay line before it reaches the output pins.

The output can run in two ways. In single-rate mode all 16 bits are presented once per clock, with a forwarded data clock whose polarity can be flipped. In double-rate mode the lower 8 pins carry the word in two halves: the even-numbered bits during the high phase of the clock and the odd-numbered bits during the low phase. An active-high disable input parks every output at 0 and drops all per-bit enables, which model the pad drivers. All configuration inputs are static levels.

Top module: `sample_out_formatter`

## Requirements
- R1: With `fmtSel` = 0 (offset binary), raw 0x8000 gives 0x0000, raw 0x0000 gives 0x8000, raw 0x7FFF gives 0xFFFF, and raw 0xFFFF gives 0x7FFF.
- R2: With `fmtSel` = 1 (two's complement), the raw word passes unchanged: 0x8000, 0x0000, 0x7FFF and 0xFFFF map to themselves.
- R3: With `fmtSel` = 2 (Gray), the output is g = b ^ (b >> 1), where b is the offset-binary word. For example, raw 0x0000 gives 0xC000 and raw 0x1234 gives 0xDB2E. `fmtSel` = 3 behaves as offset binary.
- R4: `overHigh` clamps the raw word to 0x7FFF and `overLow` clamps it to 0x8000, before encoding. `overLow` wins when both are set. `ovrOut` is 1 for a clamped sample and 0 for an in-range one.
- R5: A sample held at rising edge k is visible on `dataOut`/`ovrOut` after rising edge k+12, and not after edge k+11.
- R6: With `ddrMode` = 1, after rising edge k+12 the pins `dataOut[7:0]` carry bit 2i of the word on pin i during the high clock phase, and bit 2i+1 during the following low phase. `dataOut[15:8]` is 0, `dataEn` is 0x00FF, and `dclkOut` follows the clock.
- R7: In single-rate mode `dataEn` is 0xFFFF. `dclkOut` equals the clock when `clkInvert` = 0 and equals its inverse when `clkInvert` = 1.
- R8: While `oeBar` = 1, `dataOut`, `dataEn`, `ovrOut`, `ovrEn`, `dclkOut` and `dclkEn` are all 0. The delay line keeps running, so the data is back as soon as `oeBar` returns to 0.
- R9: A clock edge with `rst` = 1 empties the delay line, so `ovrOut` = 0 and `dataOut` = 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleIn | input | 16 | Raw sample, two's complement |
| overLow | input | 1 | Input below the negative limit |
| overHigh | input | 1 | Input above the positive limit |
| fmtSel | input | 2 | 0 offset binary, 1 two's complement, 2 Gray, 3 offset binary |
| ddrMode | input | 1 | 1 selects the double-rate 8-bit bus |
| clkInvert | input | 1 | Flips the data clock in single-rate mode |
| oeBar | input | 1 | 1 parks and disables all outputs |
| dataOut | output | 16 | Output data pins |
| dataEn | output | 16 | Per-pin drive enable |
| ovrOut | output | 1 | Overrange flag, aligned with data |
| ovrEn | output | 1 | Drive enable for the overrange pin |
| dclkOut | output | 1 | Forwarded data clock |
| dclkEn | output | 1 | Drive enable for the data clock |

## Verification
The encoder is driven with the three full-scale anchors (most negative, zero, top code) under each code, so that an inverted MSB, a missing XOR stage or a swapped select value shows up as a wrong anchor. A mid-scale pattern (0x1234) and the word -1 catch errors in the lower bits and in the Gray shift that the anchors hide. Clamped samples, including both flags raised at once, separate clamp priority from flag timing. The double-rate check uses a word whose even and odd halves differ, so a swapped phase or a shifted bit index gives a wrong byte.

// File: rtl/sof_pkg.sv
package sof_pkg;
  typedef enum logic [1:0] {
    FMT_OFFSET = 2'd0,
    FMT_TWOS   = 2'd1,
    FMT_GRAY   = 2'd2
  } fmtKind_e;

  typedef struct packed {
    fmtKind_e fmtKind;
    logic     ddrOn;
    logic     driveOn;
    logic     dclkFlip;
  } ctrlStrobes_t;
endpackage

// File: rtl/sof_ctrl.sv
module sof_ctrl
  import sof_pkg::*;
(
  input  logic [1:0]   fmtSel,
  input  logic         ddrMode,
  input  logic         clkInvert,
  input  logic         oeBar,
  output ctrlStrobes_t strobes
);
  always_comb begin
    unique case (fmtSel)
      2'd1:    strobes.fmtKind = FMT_TWOS;
      2'd2:    strobes.fmtKind = FMT_GRAY;
      default: strobes.fmtKind = FMT_OFFSET;
    endcase
    strobes.ddrOn    = ddrMode;
    strobes.driveOn  = ~oeBar;
    // polarity flip only meaningful on the single-rate bus
    strobes.dclkFlip = clkInvert & ~ddrMode;
  end
endmodule

// File: rtl/sof_datapath.sv
module sof_datapath
  import sof_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int LATENCY = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] sampleIn,
  input  logic             overLow,
  input  logic             overHigh,
  input  ctrlStrobes_t     strobes,
  output logic [WIDTH-1:0] dataOut,
  output logic [WIDTH-1:0] dataEn,
  output logic             ovrOut,
  output logic             ovrEn,
  output logic             dclkOut,
  output logic             dclkEn
);
  localparam int HALF   = WIDTH / 2;
  localparam int STAGES = LATENCY + 1;
  localparam logic [WIDTH-1:0] SIGN_BIT = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] POS_TOP  = {1'b0, {(WIDTH-1){1'b1}}};

  logic [WIDTH-1:0] clamped;
  logic [WIDTH-1:0] offsetWord;
  logic [WIDTH-1:0] fmtWord;
  logic             ovrNow;

  always_comb begin
    ovrNow = overLow | overHigh;
    if (overLow)       clamped = SIGN_BIT;
    else if (overHigh) clamped = POS_TOP;
    else               clamped = sampleIn;
    offsetWord = clamped ^ SIGN_BIT;
    unique case (strobes.fmtKind)
      FMT_TWOS: fmtWord = clamped;
      FMT_GRAY: fmtWord = offsetWord ^ (offsetWord >> 1);
      default:  fmtWord = offsetWord;
    endcase
  end

  // delay line: flag in the top bit, word below
  logic [WIDTH:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= {ovrNow, fmtWord};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  logic [WIDTH-1:0] outWord;
  logic             outOvr;
  logic [HALF-1:0]  evenHalf;
  logic [HALF-1:0]  oddHalf;

  assign outWord = pipe[STAGES-1][WIDTH-1:0];
  assign outOvr  = pipe[STAGES-1][WIDTH];

  for (genvar g = 0; g < HALF; g++) begin : g_split
    assign evenHalf[g] = outWord[2*g];
    assign oddHalf[g]  = outWord[2*g+1];
  end

  always_comb begin
    dataOut = '0;
    dataEn  = '0;
    ovrOut  = 1'b0;
    ovrEn   = 1'b0;
    dclkOut = 1'b0;
    dclkEn  = 1'b0;
    if (strobes.driveOn) begin
      ovrOut = outOvr;
      ovrEn  = 1'b1;
      dclkEn = 1'b1;
      if (strobes.ddrOn) begin
        dataOut = {{HALF{1'b0}}, (clk ? evenHalf : oddHalf)};
        dataEn  = {{HALF{1'b0}}, {HALF{1'b1}}};
        dclkOut = clk;
      end else begin
        dataOut = outWord;
        dataEn  = '1;
        dclkOut = clk ^ strobes.dclkFlip;
      end
    end
  end
endmodule

// File: rtl/sample_out_formatter.sv
module sample_out_formatter
  import sof_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int LATENCY = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] sampleIn,
  input  logic             overLow,
  input  logic             overHigh,
  input  logic [1:0]       fmtSel,
  input  logic             ddrMode,
  input  logic             clkInvert,
  input  logic             oeBar,
  output logic [WIDTH-1:0] dataOut,
  output logic [WIDTH-1:0] dataEn,
  output logic             ovrOut,
  output logic             ovrEn,
  output logic             dclkOut,
  output logic             dclkEn
);
  ctrlStrobes_t strobes;

  sof_ctrl ctrl_i (
    .fmtSel    (fmtSel),
    .ddrMode   (ddrMode),
    .clkInvert (clkInvert),
    .oeBar     (oeBar),
    .strobes   (strobes)
  );

  sof_datapath #(.WIDTH(WIDTH), .LATENCY(LATENCY)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .sampleIn (sampleIn),
    .overLow  (overLow),
    .overHigh (overHigh),
    .strobes  (strobes),
    .dataOut  (dataOut),
    .dataEn   (dataEn),
    .ovrOut   (ovrOut),
    .ovrEn    (ovrEn),
    .dclkOut  (dclkOut),
    .dclkEn   (dclkEn)
  );
endmodule

// File: rtl/sample_out_formatter_chk.sv
module sample_out_formatter_chk #(
  parameter int WIDTH   = 16,
  parameter int LATENCY = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             overLow,
  input logic             overHigh,
  input logic             ddrMode,
  input logic             oeBar,
  input logic [WIDTH-1:0] dataOut,
  input logic [WIDTH-1:0] dataEn,
  input logic             ovrOut,
  input logic             ovrEn,
  input logic             dclkOut,
  input logic             dclkEn
);
  localparam int HALF = WIDTH / 2;

  // independent flag history, one entry per cycle of latency
  logic [LATENCY:0] ovrHist;
  always_ff @(posedge clk) begin
    if (rst) ovrHist <= '0;
    else     ovrHist <= {ovrHist[LATENCY-1:0], overLow | overHigh};
  end

  p_park_r8: assert property (@(posedge clk) disable iff (rst)
    oeBar |-> (dataEn == '0 && dataOut == '0 && !ovrOut && !ovrEn && !dclkOut && !dclkEn));

  p_ddr_upper_r6: assert property (@(posedge clk) disable iff (rst)
    (ddrMode && !oeBar) |-> (dataOut[WIDTH-1:HALF] == '0 && dataEn == {{HALF{1'b0}}, {HALF{1'b1}}}));

  p_sdr_enable_r7: assert property (@(posedge clk) disable iff (rst)
    (!ddrMode && !oeBar) |-> (dataEn == '1 && dclkEn));

  p_ovr_align_r5: assert property (@(posedge clk) disable iff (rst)
    !oeBar |-> (ovrOut == ovrHist[LATENCY]));

  p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ovrOut && dataOut == '0));
endmodule

bind sample_out_formatter sample_out_formatter_chk #(.WIDTH(WIDTH), .LATENCY(LATENCY)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .overLow  (overLow),
  .overHigh (overHigh),
  .ddrMode  (ddrMode),
  .oeBar    (oeBar),
  .dataOut  (dataOut),
  .dataEn   (dataEn),
  .ovrOut   (ovrOut),
  .ovrEn    (ovrEn),
  .dclkOut  (dclkOut),
  .dclkEn   (dclkEn)
);

// File: tb/sample_out_formatter_tb_top.sv
module sample_out_formatter_tb_top;
  localparam int LAT = 12;
  localparam int NVEC = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] sampleIn = '0;
  logic        overLow = 1'b0;
  logic        overHigh = 1'b0;
  logic [1:0]  fmtSel = 2'd0;
  logic        ddrMode = 1'b0;
  logic        clkInvert = 1'b0;
  logic        oeBar = 1'b0;
  logic [15:0] dataOut;
  logic [15:0] dataEn;
  logic        ovrOut;
  logic        ovrEn;
  logic        dclkOut;
  logic        dclkEn;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sample_out_formatter #(.WIDTH(16), .LATENCY(LAT)) dut_i (
    .clk(clk), .rst(rst), .sampleIn(sampleIn), .overLow(overLow), .overHigh(overHigh),
    .fmtSel(fmtSel), .ddrMode(ddrMode), .clkInvert(clkInvert), .oeBar(oeBar),
    .dataOut(dataOut), .dataEn(dataEn), .ovrOut(ovrOut), .ovrEn(ovrEn),
    .dclkOut(dclkOut), .dclkEn(dclkEn)
  );

  // {sample, overLow, overHigh, fmtSel, expected word, expected flag}
  localparam logic [36:0] VECS [NVEC] = '{
    {16'h8000, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0},  // R1
    {16'h0000, 1'b0, 1'b0, 2'd0, 16'h8000, 1'b0},  // R1
    {16'h7FFF, 1'b0, 1'b0, 2'd0, 16'hFFFF, 1'b0},  // R1
    {16'hFFFF, 1'b0, 1'b0, 2'd0, 16'h7FFF, 1'b0},  // R1
    {16'h8000, 1'b0, 1'b0, 2'd1, 16'h8000, 1'b0},  // R2
    {16'h0000, 1'b0, 1'b0, 2'd1, 16'h0000, 1'b0},  // R2
    {16'h7FFF, 1'b0, 1'b0, 2'd1, 16'h7FFF, 1'b0},  // R2
    {16'h1234, 1'b0, 1'b0, 2'd2, 16'hDB2E, 1'b0},  // R3
    {16'h0000, 1'b0, 1'b0, 2'd2, 16'hC000, 1'b0},  // R3
    {16'h8000, 1'b0, 1'b0, 2'd2, 16'h0000, 1'b0},  // R3
    {16'h0000, 1'b0, 1'b0, 2'd3, 16'h8000, 1'b0},  // R3 default
    {16'h0100, 1'b0, 1'b1, 2'd0, 16'hFFFF, 1'b1},  // R4 high
    {16'h0100, 1'b1, 1'b0, 2'd1, 16'h8000, 1'b1},  // R4 low
    {16'h0100, 1'b0, 1'b1, 2'd2, 16'h8000, 1'b1},  // R4 gray
    {16'h0100, 1'b1, 1'b1, 2'd0, 16'h0000, 1'b1}   // R4 priority
  };

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic flush();
    repeat (LAT + 2) @(posedge clk);
    #2;
  endtask

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    // R9: reset state
    repeat (2) @(posedge clk);
    #2;
    check("R9 reset data", dataOut, 16'h0000);
    check("R9 reset ovr", {15'd0, ovrOut}, 16'h0000);
    check("R7 sdr enable", dataEn, 16'hFFFF);
    @(negedge clk) rst = 1'b0;

    // table of encodings and clamps
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      {sampleIn, overLow, overHigh, fmtSel} = VECS[v][36:17];
      flush();
      check($sformatf("R1-4 vec%0d data", v), dataOut, VECS[v][16:1]);
      check($sformatf("R4 vec%0d ovr", v), {15'd0, ovrOut}, {15'd0, VECS[v][0]});
    end

    // R5: latency exactly 12 edges
    @(negedge clk);
    {sampleIn, overLow, overHigh, fmtSel} = {16'h0000, 1'b0, 1'b0, 2'd0};
    flush();
    @(negedge clk) sampleIn = 16'h7FFF;
    @(posedge clk);
    repeat (LAT - 1) @(posedge clk);
    #2;
    check("R5 before latency", dataOut, 16'h8000);
    @(posedge clk);
    #2;
    check("R5 at latency", dataOut, 16'hFFFF);

    // R7: data clock polarity
    check("R7 dclk normal high", {15'd0, dclkOut}, 16'd1);
    @(negedge clk) clkInvert = 1'b1;
    @(posedge clk);
    #2;
    check("R7 dclk inverted high", {15'd0, dclkOut}, 16'd0);
    @(negedge clk);
    #2;
    check("R7 dclk inverted low", {15'd0, dclkOut}, 16'd1);

    // R6: double-rate split of 0x9234 (raw 0x1234, offset binary)
    @(negedge clk);
    ddrMode = 1'b1;
    sampleIn = 16'h1234;
    flush();
    check("R6 even half", dataOut, 16'h0046);
    check("R6 enable", dataEn, 16'h00FF);
    check("R6 dclk high", {15'd0, dclkOut}, 16'd1);
    @(negedge clk);
    #2;
    check("R6 odd half", dataOut, 16'h0094);
    check("R6 dclk low", {15'd0, dclkOut}, 16'd0);

    // R8: parking
    oeBar = 1'b1;
    @(posedge clk);
    #2;
    check("R8 parked data", dataOut, 16'h0000);
    check("R8 parked enable", dataEn, 16'h0000);
    check("R8 parked misc", {12'd0, ovrEn, dclkOut, dclkEn, ovrOut}, 16'h0000);
    @(negedge clk);
    #2;
    check("R8 parked dclk low", {15'd0, dclkOut}, 16'd0);
    ddrMode = 1'b0;
    clkInvert = 1'b0;
    oeBar = 1'b0;
    @(posedge clk);
    #2;
    check("R8 restored data", dataOut, 16'h9234);

    // R9: reset mid-run clears a pending overrange
    @(negedge clk) overHigh = 1'b1;
    flush();
    check("R9 flag before reset", {15'd0, ovrOut}, 16'd1);
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    #2;
    check("R9 flag cleared", {15'd0, ovrOut}, 16'd0);
    check("R9 data cleared", dataOut, 16'h0000);
    @(negedge clk) rst = 1'b0;
    @(posedge clk);

    finishRun();
  end
endmodule